// File: doc/BRIEF.md
# Bus Access Self-Test Window

This block is a small memory-mapped register window that software uses to confirm that its reads and writes of each width reach the hardware intact. Software picks a test by writing its number into a select byte. The window then reports the access width that test expects, the byte address inside the window where software must write, and the value to write. It also returns a short zero-terminated ASCII label for the test. Each write that matches the selected test in address, byte lanes and data increments a counter that software can read back.

The test table is fixed at elaboration time, and the tests are numbered contiguously from zero. Any number past the last test reports width code 0. Software can therefore discover the table by stepping the select value until that code appears. The bus is a synchronous register port with a byte address, 32-bit write data, byte enables, and single-cycle read and write strobes. The window spans 4 KB, and read data is registered.

Top module: `bus_selftest_window`

## Requirements
- R1: The 32-bit word at byte offset 0 reads with byte 0 (the select byte, write-only) as zero, byte 1 as the width code of the selected test, and bytes 2 and 3 as zero.
- R2: The width code is 1, 2 or 4 for a byte, 16-bit or 32-bit test. Tests 0, 1 and 2 are byte at offset 0x041 with data 0xA5, 16-bit at offset 0x082 with data 0xBEEF, and 32-bit at offset 0x0C0 with data 0xCAFEF00D. Every select value of 3 or above yields width code 0.
- R3: The word at byte offset 4 reads the selected test's target byte offset, and the word at offset 8 reads its data value. Both are little endian, with the least significant byte at the lowest address.
- R4: Bytes 16 to 31 hold the test label, character 0 at byte 16, followed by a zero terminator and zero fill. The labels are "byte-wr", "half-wr" and "word-wr".
- R5: A write counts only when all of the following hold: its byte address equals the target offset; its byte enables are exactly the lanes of that width starting at lane offset[1:0]; and each enabled lane of the write data equals the test data shifted left by 8*offset[1:0]. Each such write adds one to the count, which is read zero-extended at byte offset 12.
- R6: A write with the wrong address, the wrong byte enables or the wrong lane data does not change the count. Neither does any write below byte offset 32.
- R7: A write to word 0 with byte enable 0 set loads the select byte from wdata[7:0] and clears the count to zero, even when the same number is selected again.
- R8: The count saturates at 2^CNT_W-1 and does not wrap.
- R9: While an unsupported number is selected, the offset, data and label read as zero, and no write changes the count.
- R10: Reads of word offsets 32 and above return zero. Writes to the offset, data, count and label words are ignored.
- R11: rdata updates on the clock edge that samples rd_en high. It holds its value while rd_en is low.
- R12: After reset, the select byte holds 0xFF (unsupported), the count is zero and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address within the window |
| wdata | input | 32 | Write data, little endian lanes |
| be | input | 4 | Byte enables for wdata lanes |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 32 | Registered read data |

## Verification
The hardest state to reach from the ports is a count sitting at its ceiling while writes that nearly qualify keep arriving. Such writes differ from the test in a single byte-enable bit, a single data bit or one word of address. The bench builds the DUT with a 4-bit counter so the ceiling of 15 is reachable. It then issues bursts of exact matches mixed with these near misses and with header writes. A software model tracks the saturating count and compares it at each read-back. Unsupported selections are fed the pattern of a real test, to show that the pattern alone never counts.

// File: rtl/bst_pkg.sv
package bst_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int NAME_BYTES = 16;
    localparam int NAME_W     = NAME_BYTES * 8;
    localparam int NAME_WORDS = NAME_BYTES / LANES;
    localparam int NAME_BASE  = 16;
    localparam int HDR_BYTES  = NAME_BASE + NAME_BYTES;
    localparam int NUM_TESTS  = 3;
    localparam logic [7:0] BAD_WIDTH = 8'h00;
    localparam logic [7:0] RESET_SEL = 8'hFF;

    typedef struct packed {
        logic              valid;
        logic [7:0]        width;
        logic [ADDR_W-1:0] offset;
        logic [DATA_W-1:0] data;
    } test_rec_t;

    function automatic test_rec_t lookup_test(input logic [7:0] num);
        test_rec_t r;
        r = '0;
        r.width = BAD_WIDTH;
        case (num)
            8'd0: begin r.valid = 1'b1; r.width = 8'd1; r.offset = 12'h041; r.data = 32'h0000_00A5; end
            8'd1: begin r.valid = 1'b1; r.width = 8'd2; r.offset = 12'h082; r.data = 32'h0000_BEEF; end
            8'd2: begin r.valid = 1'b1; r.width = 8'd4; r.offset = 12'h0C0; r.data = 32'hCAFE_F00D; end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [NAME_W-1:0] name_literal(input logic [7:0] num);
        case (num)
            8'd0:    return NAME_W'("byte-wr");
            8'd1:    return NAME_W'("half-wr");
            8'd2:    return NAME_W'("word-wr");
            default: return '0;
        endcase
    endfunction

    // Character idx of the label; literals are right-justified, first char highest.
    function automatic logic [7:0] name_char(input logic [7:0] num, input int idx);
        logic [NAME_W-1:0] lit;
        int n;
        lit = name_literal(num);
        n = 0;
        for (int i = 0; i < NAME_BYTES; i++) begin
            if (lit[8*i +: 8] != 8'h00) n++;
        end
        if (idx < n) return lit[8*(n-1-idx) +: 8];
        return 8'h00;
    endfunction

endpackage

// File: rtl/bst_test_table.sv
module bst_test_table
    import bst_pkg::*;
(
    input  logic [7:0]        sel,
    output test_rec_t         rec,
    output logic [NAME_W-1:0] name
);

    assign rec = lookup_test(sel);

    for (genvar g = 0; g < NAME_BYTES; g++) begin : g_name
        assign name[8*g +: 8] = rec.valid ? name_char(sel, g) : 8'h00;
    end

    always_comb begin
        if (rec.valid) begin
            AST_WIDTH_LEGAL: assert (rec.width == 8'd1 || rec.width == 8'd2 || rec.width == 8'd4); // R2
        end
    end

endmodule

// File: rtl/bst_write_match.sv
module bst_write_match
    import bst_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  test_rec_t         rec,
    output logic              hit
);

    logic [1:0]        lane_sh;
    logic [LANES-1:0]  exp_be;
    logic [DATA_W-1:0] exp_lanes;
    logic [LANES-1:0]  lane_ok;
    logic              outside_hdr;

    assign lane_sh   = rec.offset[1:0];
    assign exp_lanes = rec.data << {lane_sh, 3'b000};

    always_comb begin
        case (rec.width)
            8'd1:    exp_be = 4'(4'b0001 << lane_sh);
            8'd2:    exp_be = 4'(4'b0011 << lane_sh);
            8'd4:    exp_be = 4'b1111;
            default: exp_be = 4'b0000;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] = !exp_be[g] || (wdata[8*g +: 8] == exp_lanes[8*g +: 8]);
    end

    assign outside_hdr = int'(addr) >= HDR_BYTES;

    assign hit = wr_en && rec.valid && outside_hdr && (addr == rec.offset)
              && (be == exp_be) && (&lane_ok);

endmodule

// File: rtl/bst_read_mux.sv
module bst_read_mux
    import bst_pkg::*;
(
    input  logic [ADDR_W-3:0] word,
    input  test_rec_t         rec,
    input  logic [NAME_W-1:0] name,
    input  logic [DATA_W-1:0] cnt_ext,
    output logic [DATA_W-1:0] rd_val
);

    int w;
    assign w = int'(word);

    always_comb begin
        rd_val = '0;
        if (w == 0) begin
            rd_val = {16'h0000, rec.width, 8'h00};
        end else if (w == 1) begin
            rd_val = DATA_W'(rec.offset);
        end else if (w == 2) begin
            rd_val = rec.data;
        end else if (w == 3) begin
            rd_val = cnt_ext;
        end else if (w >= NAME_BASE / LANES && w < NAME_BASE / LANES + NAME_WORDS) begin
            rd_val = name[DATA_W*(w - NAME_BASE / LANES) +: DATA_W];
        end
    end

endmodule

// File: rtl/bus_selftest_window.sv
module bus_selftest_window
    import bst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [7:0]        sel;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    test_rec_t         rec;
    logic [NAME_W-1:0] name;
    logic              hit;
    logic              sel_wr;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] cnt_ext;

    assign sel_wr  = wr_en && (addr[ADDR_W-1:2] == '0) && be[0];
    assign cnt_ext = DATA_W'(st_q.cnt);

    bst_test_table u_table (
        .sel  (st_q.sel),
        .rec  (rec),
        .name (name)
    );

    bst_write_match u_match (
        .wr_en (wr_en),
        .addr  (addr),
        .be    (be),
        .wdata (wdata),
        .rec   (rec),
        .hit   (hit)
    );

    bst_read_mux u_rmux (
        .word    (addr[ADDR_W-1:2]),
        .rec     (rec),
        .name    (name),
        .cnt_ext (cnt_ext),
        .rd_val  (rd_val)
    );

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            st_d.sel = wdata[7:0];
            st_d.cnt = '0;
        end else if (hit && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rd_en) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel   <= RESET_SEL;
            st_q.cnt   <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11

    AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> st_q.cnt == '0); // R7

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !sel_wr) |=> st_q.cnt == CNT_MAX); // R8

    AST_UNSUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec.valid && !sel_wr) |=> $stable(st_q.cnt)); // R9

    AST_HDR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) < HDR_BYTES && !sel_wr) |=> $stable(st_q.cnt)); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R5

endmodule

// File: tb/bus_selftest_window_bench.sv
module bus_selftest_window_bench;

    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    int model_cnt;

    always #5 clk = ~clk;

    bus_selftest_window #(.CNT_W(CW)) u_bus_selftest_window (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .be(be),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
    );

    function automatic int exp_width(int t);
        case (t) 0: return 1; 1: return 2; 2: return 4; default: return 0; endcase
    endfunction
    function automatic logic [11:0] exp_off(int t);
        case (t) 0: return 12'h041; 1: return 12'h082; 2: return 12'h0C0; default: return 12'h000; endcase
    endfunction
    function automatic logic [31:0] exp_data(int t);
        case (t) 0: return 32'hA5; 1: return 32'hBEEF; 2: return 32'hCAFEF00D; default: return 32'h0; endcase
    endfunction
    function automatic string exp_name(int t);
        case (t) 0: return "byte-wr"; 1: return "half-wr"; 2: return "word-wr"; default: return ""; endcase
    endfunction
    function automatic logic [31:0] exp_name_word(int t, int w);
        logic [31:0] v = '0;
        string s = exp_name(t);
        for (int b = 0; b < 4; b++) begin
            int i = 4*w + b;
            if (i < s.len()) v[8*b +: 8] = s[i];
        end
        return v;
    endfunction
    function automatic logic [3:0] exp_be(int t);
        logic [1:0] sh = exp_off(t)[1:0];
        case (exp_width(t))
            1: return 4'(4'b0001 << sh);
            2: return 4'(4'b0011 << sh);
            4: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction
    function automatic logic [31:0] exp_lanes(int t);
        return exp_data(t) << (8 * exp_off(t)[1:0]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        addr = a; wdata = d; be = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic select(input int t);
        bus_write(12'h000, 32'(t) | 32'hA5A5_5A00, 4'b0001);
        model_cnt = 0;
    endtask

    task automatic exact_write(input int t);
        logic [31:0] m = '0;
        logic [3:0] b = exp_be(t);
        for (int g = 0; g < 4; g++) if (b[g]) m[8*g +: 8] = 8'hFF;
        bus_write(exp_off(t), (exp_lanes(t) & m) | ($urandom & ~m), b);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        check("R12 rdata after reset", rdata, 32'h0);
        bus_read(12'h000, d); check("R12 header after reset", d, 32'h0);
        bus_read(12'h00C, d); check("R12 count after reset", d, 32'h0);

        for (int t = 0; t < 6; t++) begin
            select(t);
            bus_read(12'h000, d); check("R1 R2 header word", d, {16'h0, 8'(exp_width(t)), 8'h00});
            bus_read(12'h004, d); check("R3 offset", d, 32'(exp_off(t)));
            bus_read(12'h008, d); check("R3 data", d, exp_data(t));
            for (int w = 0; w < 4; w++) begin
                bus_read(12'(16 + 4*w), d);
                check(t < 3 ? "R4 name word" : "R9 name zero", d, exp_name_word(t, w));
            end
        end

        select(1);
        bus_write(12'h004, 32'hFFFF_FFFF, 4'hF);
        bus_write(12'h008, 32'hFFFF_FFFF, 4'hF);
        bus_read(12'h004, d); check("R10 offset ignores write", d, 32'h082);
        bus_read(12'h008, d); check("R10 data ignores write", d, 32'hBEEF);
        bus_read(12'h020, d); check("R10 unimplemented word", d, 32'h0);
        bus_read(12'h800, d); check("R10 high address", d, 32'h0);

        for (int t = 0; t < 3; t++) begin
            select(t);
            exact_write(t);
            bus_read(12'h00C, d); check("R5 single match", d, 32'h1);
            select(t);
            bus_read(12'h00C, d); check("R7 reselect clears", d, 32'h0);
        end

        select(2);
        for (int i = 0; i < 20; i++) exact_write(2);
        bus_read(12'h00C, d); check("R8 saturate", d, 32'(CMAX));

        select(9);
        for (int i = 0; i < 3; i++) exact_write(i);
        bus_read(12'h00C, d); check("R9 unsupported no count", d, 32'h0);

        begin : r11_hold
            bus_read(12'h004, d);
            repeat (3) @(negedge clk);
            check("R11 rdata held", rdata, d);
        end

        for (int it = 0; it < 40; it++) begin
            int t = $urandom_range(0, 3);
            int pt = (t == 3) ? 0 : t;
            select(t == 3 ? 200 : t);
            for (int k = 0; k < 30; k++) begin
                int kind = $urandom_range(0, 5);
                logic [31:0] m = '0;
                logic [3:0] b = exp_be(pt);
                for (int g = 0; g < 4; g++) if (b[g]) m[8*g +: 8] = 8'hFF;
                case (kind)
                    0, 1: begin
                        bus_write(exp_off(pt), (exp_lanes(pt) & m) | ($urandom & ~m), b);
                        if (t != 3 && model_cnt < CMAX) model_cnt++;
                    end
                    2: bus_write(exp_off(pt), exp_lanes(pt) ^ (32'h1 << (8 * exp_off(pt)[1:0])), b);
                    3: bus_write(exp_off(pt), exp_lanes(pt), b ^ 4'b1000);
                    4: bus_write(exp_off(pt) + 12'h4, exp_lanes(pt), b);
                    default: bus_write(12'(4 * $urandom_range(1, 7)), $urandom, 4'hF);
                endcase
            end
            bus_read(12'h00C, d);
            check(t == 3 ? "R9 random unsupported" : "R5 R6 R8 random count", d, 32'(model_cnt));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule